// File: doc/BRIEF.md
# DMA Bus Burst Planner

This block sits between a transmit DMA engine, a receive DMA engine and one system bus master port. An engine asks for a word transfer of a given length. The planner picks one engine and breaks the transfer into a series of bus bursts. It shows the burst type and beat count of each burst on the bus side, counts the beats the bus accepts, and pulses a done line back to the engine that owns the transfer.

The burst shape follows three control bits: fixed-length bursts only, mixed shaping, and rebuild style. A fourth bit picks which engine wins when both ask at the same time. The bus can break a burst with a retry response, a split response or by taking the grant away. When that happens the beat on offer is not counted. The beats still owed by the broken burst are issued again in the style the rebuild bit selects, and normal shaping then resumes for the rest of the transfer. The control bits must be held steady while a transfer is in flight.

Top module: `dma_burst_planner`

## Requirements
- R1: After reset no burst is presented (`bus_busy` low) and neither done line is high.
- R2: When both engines request in the same idle cycle, the receive engine is served first if `cfg_tx_first` is 0 and the transmit engine if it is 1. The winning engine keeps the bus until its transfer is done, and `bus_owner` (1 = transmit) does not change during a burst.
- R3: With `cfg_fixed` set, each burst is the largest of 16, 8, 4 or 1 beats that fits in the remaining count. The types are SINGLE=000, INCR4=011, INCR8=101 and INCR16=111, with `bus_blen` matching the type.
- R4: With `cfg_fixed` clear and `cfg_mixed` set, a remaining count above 16 is issued as one INCR (001) burst of that whole count. A count of 16 or less is shaped as in R3.
- R5: With both `cfg_fixed` and `cfg_mixed` clear, a remaining count of two or more is one INCR burst of that count, and a count of one is a SINGLE.
- R6: In a cycle where the bus shows retry, split or grant low, the offered beat is not accepted. The beats the interrupted burst still owed are then re-issued.
- R7: With `cfg_rebuild` clear, re-issued pending beats P go out as one INCR burst of P-1 beats followed by one SINGLE when P is 3 or more, and as SINGLE bursts when P is 2 or less.
- R8: With `cfg_rebuild` set, re-issued pending beats are shaped by the fixed rule of R3 applied to P.
- R9: Once the pending beats of an interrupted burst are issued, the rest of the transfer is shaped by R3 to R5 again.
- R10: The owner's done line is high for exactly one cycle, in the cycle after the last beat is accepted. The number of accepted beats equals the requested length.
- R11: A request of length zero produces a done pulse to that engine and no burst.
- R12: Type, length and owner stay constant while `bus_busy` is high. `bus_busy` drops for at least one cycle between consecutive bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fixed | input | 1 | Use only fixed-length bursts |
| cfg_mixed | input | 1 | Mixed shaping when fixed is off |
| cfg_rebuild | input | 1 | Re-issue interrupted beats with fixed bursts |
| cfg_tx_first | input | 1 | Transmit engine wins arbitration |
| tx_req | input | 1 | Transmit engine request, held until done |
| tx_len | input | LEN_W | Transmit transfer length in words |
| rx_req | input | 1 | Receive engine request, held until done |
| rx_len | input | LEN_W | Receive transfer length in words |
| tx_done | output | 1 | One-cycle completion pulse to transmit engine |
| rx_done | output | 1 | One-cycle completion pulse to receive engine |
| bus_ack | input | 1 | Bus accepts the offered beat |
| bus_retry | input | 1 | Retry response |
| bus_split | input | 1 | Split response |
| bus_grant | input | 1 | Bus grant held by this master |
| bus_busy | output | 1 | A burst is being offered |
| bus_first | output | 1 | No beat of the current burst accepted yet |
| bus_burst | output | 3 | Burst type code |
| bus_blen | output | LEN_W | Beats in the current burst |
| bus_owner | output | 1 | Engine of the current burst, 1 = transmit |

## Verification
The bound checker watches, on every cycle, the rules that do not depend on history: only legal type codes appear, a fixed type carries its own beat count, no INCR appears in fixed mode or during a fixed-style rebuild, done pulses are single and never both at once, and type, length and owner stay frozen while a burst is offered. The exact order of bursts, meaning the shaping of each length, the re-issued split after a retry, split or grant loss at a given beat, the resumed normal shaping, and which engine goes first, depends on whole sequences. Only the bench's scenarios show these, by checking each burst against the list it expects. Beat totals per transfer and the zero-length case are also bench-only.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  typedef enum logic [2:0] {
    BT_SINGLE = 3'b000,
    BT_INCR   = 3'b001,
    BT_INCR4  = 3'b011,
    BT_INCR8  = 3'b101,
    BT_INCR16 = 3'b111
  } burst_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DONE
  } seq_t;

  // largest fixed burst size (16, 8, 4, 1) not above n
  function automatic int unsigned fit_fixed(input int unsigned n);
    if (n >= 16)     return 16;
    else if (n >= 8) return 8;
    else if (n >= 4) return 4;
    else             return 1;
  endfunction

  function automatic burst_t fixed_type(input int unsigned beats);
    case (beats)
      16:      return BT_INCR16;
      8:       return BT_INCR8;
      4:       return BT_INCR4;
      default: return BT_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/dbp_arbiter.sv
module dbp_arbiter (
  input  logic tx_req,
  input  logic rx_req,
  input  logic tx_first,
  output logic pick_valid,
  output logic pick_tx
);

  assign pick_valid = tx_req | rx_req;

  always_comb begin
    if (tx_req && rx_req) pick_tx = tx_first;
    else                  pick_tx = tx_req;
  end

endmodule

// File: rtl/dbp_shaper.sv
module dbp_shaper
  import dbp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [LEN_W-1:0] rem,
  input  logic [LEN_W-1:0] pend,
  input  logic             cfg_fixed,
  input  logic             cfg_mixed,
  input  logic             cfg_rebuild,
  output burst_t           shp_type,
  output logic [LEN_W-1:0] shp_len
);

  localparam int unsigned MIX_LIMIT = 16;

  logic [31:0] r_w, p_w, l_w;
  burst_t      t_w;

  always_comb begin
    r_w = 32'(rem);
    p_w = 32'(pend);
    if (p_w != 0) begin
      if (cfg_rebuild) begin
        l_w = fit_fixed(p_w);
        t_w = fixed_type(l_w);
      end else if (p_w >= 3) begin
        l_w = p_w - 1;
        t_w = BT_INCR;
      end else begin
        l_w = 1;
        t_w = BT_SINGLE;
      end
    end else if (cfg_fixed || (cfg_mixed && r_w <= MIX_LIMIT)) begin
      l_w = fit_fixed(r_w);
      t_w = fixed_type(l_w);
    end else if (r_w >= 2) begin
      l_w = r_w;
      t_w = BT_INCR;
    end else begin
      l_w = 1;
      t_w = BT_SINGLE;
    end
  end

  assign shp_type = t_w;
  assign shp_len  = l_w[LEN_W-1:0];

endmodule

// File: rtl/dbp_sequencer.sv
module dbp_sequencer
  import dbp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic             pick_tx,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  burst_t           shp_type,
  input  logic [LEN_W-1:0] shp_len,
  input  logic             bus_ack,
  input  logic             bus_retry,
  input  logic             bus_split,
  input  logic             bus_grant,
  output logic [LEN_W-1:0] rem_q,
  output logic [LEN_W-1:0] pend_q,
  output logic             busy,
  output logic             first,
  output burst_t           cur_type,
  output logic [LEN_W-1:0] cur_len,
  output logic             owner,
  output logic             done_tx,
  output logic             done_rx,
  output logic             beat_ok,
  output logic             intr,
  output logic             in_rebuild
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_t             st;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] new_len;

  assign new_len    = pick_tx ? tx_len : rx_len;
  assign busy       = (st == ST_RUN);
  assign intr       = busy & (bus_retry | bus_split | ~bus_grant);
  assign beat_ok    = busy & bus_ack & ~intr;
  assign first      = busy & (left_q == cur_len);
  assign in_rebuild = (pend_q != '0);
  assign done_tx    = (st == ST_DONE) &  owner;
  assign done_rx    = (st == ST_DONE) & ~owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      owner    <= 1'b0;
      rem_q    <= '0;
      pend_q   <= '0;
      left_q   <= '0;
      cur_type <= BT_SINGLE;
      cur_len  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (pick_valid) begin
          owner  <= pick_tx;
          rem_q  <= new_len;
          pend_q <= '0;
          st     <= (new_len == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: begin
          cur_type <= shp_type;
          cur_len  <= shp_len;
          left_q   <= shp_len;
          st       <= ST_RUN;
        end
        ST_RUN: begin
          if (intr) begin
            if (pend_q == '0) pend_q <= left_q;
            st <= ST_LOAD;
          end else if (beat_ok) begin
            rem_q  <= rem_q - ONE;
            left_q <= left_q - ONE;
            if (pend_q != '0) pend_q <= pend_q - ONE;
            if (rem_q == ONE)       st <= ST_DONE;
            else if (left_q == ONE) st <= ST_LOAD;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner
  import dbp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fixed,
  input  logic             cfg_mixed,
  input  logic             cfg_rebuild,
  input  logic             cfg_tx_first,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             rx_req,
  input  logic [LEN_W-1:0] rx_len,
  output logic             tx_done,
  output logic             rx_done,
  input  logic             bus_ack,
  input  logic             bus_retry,
  input  logic             bus_split,
  input  logic             bus_grant,
  output logic             bus_busy,
  output logic             bus_first,
  output logic [2:0]       bus_burst,
  output logic [LEN_W-1:0] bus_blen,
  output logic             bus_owner
);

  logic             pick_valid, pick_tx;
  logic             idle_pick;
  burst_t           shp_type, cur_type;
  logic [LEN_W-1:0] shp_len, rem_q, pend_q;
  logic             beat_ok, intr, in_rebuild;

  // arbitration only matters while no transfer holds the bus
  assign idle_pick = pick_valid & ~bus_busy;

  dbp_arbiter u_arb (
    .tx_req     (tx_req),
    .rx_req     (rx_req),
    .tx_first   (cfg_tx_first),
    .pick_valid (pick_valid),
    .pick_tx    (pick_tx)
  );

  dbp_shaper #(.LEN_W(LEN_W)) u_shp (
    .rem         (rem_q),
    .pend        (pend_q),
    .cfg_fixed   (cfg_fixed),
    .cfg_mixed   (cfg_mixed),
    .cfg_rebuild (cfg_rebuild),
    .shp_type    (shp_type),
    .shp_len     (shp_len)
  );

  dbp_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (idle_pick),
    .pick_tx    (pick_tx),
    .tx_len     (tx_len),
    .rx_len     (rx_len),
    .shp_type   (shp_type),
    .shp_len    (shp_len),
    .bus_ack    (bus_ack),
    .bus_retry  (bus_retry),
    .bus_split  (bus_split),
    .bus_grant  (bus_grant),
    .rem_q      (rem_q),
    .pend_q     (pend_q),
    .busy       (bus_busy),
    .first      (bus_first),
    .cur_type   (cur_type),
    .cur_len    (bus_blen),
    .owner      (bus_owner),
    .done_tx    (tx_done),
    .done_rx    (rx_done),
    .beat_ok    (beat_ok),
    .intr       (intr),
    .in_rebuild (in_rebuild)
  );

  assign bus_burst = cur_type;

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fixed,
  input logic             cfg_rebuild,
  input logic             bus_busy,
  input logic [2:0]       bus_burst,
  input logic [LEN_W-1:0] bus_blen,
  input logic             bus_owner,
  input logic             tx_done,
  input logic             rx_done,
  input logic             beat_ok,
  input logic             intr,
  input logic             in_rebuild
);

  p_legal_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> (bus_burst inside {3'b000, 3'b001, 3'b011, 3'b101, 3'b111}));

  p_fixed_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && bus_burst != 3'b001) |->
      (bus_blen == ((bus_burst == 3'b111) ? LEN_W'(16) :
                    (bus_burst == 3'b101) ? LEN_W'(8)  :
                    (bus_burst == 3'b011) ? LEN_W'(4)  : LEN_W'(1))));

  p_no_incr_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && cfg_fixed && !in_rebuild) |-> (bus_burst != 3'b001));

  p_rebuild_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && in_rebuild && cfg_rebuild) |-> (bus_burst != 3'b001));

  p_beat_or_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_ok && intr));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && rx_done));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_done) |=> !(tx_done || rx_done));

  p_stable_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && $past(bus_busy)) |-> ($stable(bus_burst) && $stable(bus_blen)));

  p_owner_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && $past(bus_busy)) |-> $stable(bus_owner));

endmodule

bind dma_burst_planner dbp_checker #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/dma_burst_planner_bench.sv
module dma_burst_planner_bench;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_fixed = 0, cfg_mixed = 0, cfg_rebuild = 0, cfg_tx_first = 0;
  logic             tx_req = 0, rx_req = 0;
  logic [LEN_W-1:0] tx_len = '0, rx_len = '0;
  logic             tx_done, rx_done;
  logic             bus_ack = 1, bus_retry = 0, bus_split = 0, bus_grant = 1;
  logic             bus_busy, bus_first, bus_owner;
  logic [2:0]       bus_burst;
  logic [LEN_W-1:0] bus_blen;

  always #10 clk = ~clk;

  dma_burst_planner #(.LEN_W(LEN_W)) u_dma_burst_planner (.*);

  int total = 0, bad = 0;
  logic [11:0] exp_q[$];   // {owner, type[2:0], len[7:0]}
  string cur_tag = "R1";
  int fault_kind = 0;      // 1 retry, 2 split, 3 grant loss
  int fault_at = 0;
  int acc = 0, tx_beats = 0, rx_beats = 0;
  int tx_dn = 0, rx_dn = 0;
  logic prev_busy = 0, prev_txd = 0, prev_rxd = 0;
  logic [2:0] last_t;
  logic [LEN_W-1:0] last_l;
  logic finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input bit own, input int t, input int len);
    exp_q.push_back({own, 3'(t), 8'(len)});
  endtask

  // monitor and bus responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_busy && !prev_busy) begin
        if (exp_q.size() == 0) chk(0, cur_tag, "unexpected burst type", int'(bus_burst), -1);
        else begin
          logic [11:0] it;
          it = exp_q.pop_front();
          chk(bus_owner == it[11], cur_tag, "burst owner", int'(bus_owner), int'(it[11]));
          chk(bus_burst == it[10:8], cur_tag, "burst type", int'(bus_burst), int'(it[10:8]));
          chk(bus_blen == it[7:0], cur_tag, "burst length", int'(bus_blen), int'(it[7:0]));
        end
      end
      if (bus_busy && prev_busy)
        chk(bus_burst == last_t && bus_blen == last_l, "R12", "burst shape held",
            int'(bus_blen), int'(last_l));
      prev_busy = bus_busy;
      last_t = bus_burst;
      last_l = bus_blen;
      if (tx_done && prev_txd) chk(0, "R10", "tx done wider than one cycle", 2, 1);
      if (rx_done && prev_rxd) chk(0, "R10", "rx done wider than one cycle", 2, 1);
      prev_txd = tx_done;
      prev_rxd = rx_done;
      if (tx_done) begin tx_dn++; tx_req = 0; end
      if (rx_done) begin rx_dn++; rx_req = 0; end
      bus_retry = 0; bus_split = 0; bus_grant = 1; bus_ack = 1;
      if (bus_busy) begin
        if (fault_kind != 0 && acc == fault_at) begin
          if (fault_kind == 1) bus_retry = 1;
          else if (fault_kind == 2) bus_split = 1;
          else bus_grant = 0;
          fault_kind = 0;
        end else begin
          acc++;
          if (bus_owner) tx_beats++; else rx_beats++;
        end
      end
    end
  end

  task automatic xfer(input bit do_tx, input bit do_rx, input int tl, input int rl,
                      input int fk, input int fa);
    int t0, r0;
    t0 = tx_dn; r0 = rx_dn;
    acc = 0; tx_beats = 0; rx_beats = 0;
    fault_kind = fk; fault_at = fa;
    tx_len = LEN_W'(tl); rx_len = LEN_W'(rl);
    tx_req = do_tx; rx_req = do_rx;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!tx_req && !rx_req) break;
      if (i == 2999) chk(0, cur_tag, "transfer timed out", i, 0);
    end
    @(negedge clk);
    chk(exp_q.size() == 0, cur_tag, "bursts left unseen", exp_q.size(), 0);
    exp_q.delete();
    chk(tx_dn - t0 == int'(do_tx), "R10", "tx done pulses", tx_dn - t0, int'(do_tx));
    chk(rx_dn - r0 == int'(do_rx), "R10", "rx done pulses", rx_dn - r0, int'(do_rx));
    chk(tx_beats == (do_tx ? tl : 0), "R10", "tx beats accepted", tx_beats, do_tx ? tl : 0);
    chk(rx_beats == (do_rx ? rl : 0), "R10", "rx beats accepted", rx_beats, do_rx ? rl : 0);
  endtask

  task automatic setcfg(input bit f, input bit m, input bit rb, input bit tf);
    cfg_fixed = f; cfg_mixed = m; cfg_rebuild = rb; cfg_tx_first = tf;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_busy && !tx_done && !rx_done, "R1", "idle during reset", int'(bus_busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_busy, "R1", "busy after reset", int'(bus_busy), 0);
    chk(!tx_done && !rx_done, "R1", "done after reset", int'(tx_done | rx_done), 0);

    // R3 fixed shaping
    cur_tag = "R3"; setcfg(1, 0, 0, 0);
    push(1, 7, 16); push(1, 5, 8); push(1, 3, 4); push(1, 0, 1);
    xfer(1, 0, 29, 0, 0, 0);

    // R4 mixed shaping
    cur_tag = "R4"; setcfg(0, 1, 0, 0);
    push(0, 5, 8); push(0, 3, 4); push(0, 0, 1);
    xfer(0, 1, 0, 13, 0, 0);
    push(0, 1, 20);
    xfer(0, 1, 0, 20, 0, 0);
    push(0, 7, 16);
    xfer(0, 1, 0, 16, 0, 0);

    // R5 plain undefined bursts
    cur_tag = "R5"; setcfg(0, 0, 0, 0);
    push(1, 1, 6);
    xfer(1, 0, 6, 0, 0, 0);
    push(1, 0, 1);
    xfer(1, 0, 1, 0, 0, 0);

    // R2 arbitration both ways
    cur_tag = "R2"; setcfg(0, 0, 0, 0);
    push(0, 1, 5); push(1, 1, 3);
    xfer(1, 1, 3, 5, 0, 0);
    setcfg(0, 0, 0, 1);
    push(1, 1, 3); push(0, 1, 5);
    xfer(1, 1, 3, 5, 0, 0);

    // R6 R7 retry, rebuild clear: 11 pending -> INCR 10 + SINGLE
    cur_tag = "R7"; setcfg(1, 0, 0, 0);
    push(0, 7, 16); push(0, 1, 10); push(0, 0, 1);
    xfer(0, 1, 0, 16, 1, 5);
    // R7 two pending -> two singles
    push(0, 3, 4); push(0, 0, 1); push(0, 0, 1);
    xfer(0, 1, 0, 4, 1, 2);

    // R6 R8 retry, rebuild set: 11 pending -> 8 + 1 + 1 + 1
    cur_tag = "R8"; setcfg(1, 0, 1, 0);
    push(0, 7, 16); push(0, 5, 8); push(0, 0, 1); push(0, 0, 1); push(0, 0, 1);
    xfer(0, 1, 0, 16, 1, 5);

    // R6 R9 split, then normal shaping of the remaining 4
    cur_tag = "R9"; setcfg(1, 0, 1, 0);
    push(1, 7, 16); push(1, 5, 8); push(1, 3, 4); push(1, 0, 1); push(1, 0, 1);
    push(1, 3, 4);
    xfer(1, 0, 20, 0, 2, 2);

    // R6 grant loss, plain mode, rebuild clear: 5 pending -> INCR 4 + SINGLE
    cur_tag = "R6"; setcfg(0, 0, 0, 0);
    push(1, 1, 8); push(1, 1, 4); push(1, 0, 1);
    xfer(1, 0, 8, 0, 3, 3);

    // R11 zero length
    cur_tag = "R11"; setcfg(0, 0, 0, 0);
    xfer(1, 0, 0, 0, 0, 0);
    xfer(0, 1, 0, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule